// File: doc/BRIEF.md
# Burst-of-Two Double-Rate SRAM Command Front End

This block is the synchronous command front end of a static memory that moves two data beats per command. On every rising clock edge it samples a set of control pins and picks one of four operating states: held in reset, configuration write, loopback, or normal memory operation. In memory operation each sampled cycle carries one command: idle, write, read or configuration write. The two half-cycle data beats of a transfer appear here as one double-width pair on a single-rate clock. The lower half is the first beat and the upper half is the second.

Write pairs go straight into a small register array in the command cycle. For a read, the array is looked up when the command is sampled. The pair then travels with the command type down a fixed-length shift chain. The result reaches the output pins a fixed number of edges later, with an output-enable flag for that slot. Loopback takes the same path and echoes the input pair. A configuration write latches the address pins into a configuration register that is visible on its own output.

Top module: `b2fe_frontend`

## Requirements
- R1: While `ctl_reset` is high, every other control input is ignored. Nothing is written to the array, `cfg_value` is unchanged, and the edge that samples it clears every slot in flight, so `dout_oe` is 0 and `dout` is 0 after that edge.
- R2: While `rst_n` is low, `dout_oe` is 0, `dout` is 0 and `cfg_value` is 0.
- R3: Mode priority is fixed: `ctl_reset` first, then `ctl_cfg_wr`, then `ctl_loop`, then memory operation.
- R4: With `ctl_reset` and `ctl_cfg_wr` low and `ctl_loop` high, the `din` pair is echoed on `dout` with `dout_oe` = 1, LAT edges after the sampling edge. The array is not written.
- R5: In memory operation with `ctl_load_n` high, the cycle is idle: `addr`, `ctl_rd_wrn` and `din` have no effect on the array.
- R6: `ctl_load_n` low with `ctl_rd_wrn` high is a read. The stored pair appears on `dout` with `dout_oe` = 1 after the LAT-th edge following the sampling edge, with the first beat in bits [DW-1:0].
- R7: For an idle or write command, the output slot LAT edges later has `dout_oe` = 0 and `dout` = 0.
- R8: With `ctl_reset` low and `ctl_cfg_wr` high, `ctl_load_n` low loads `addr` into `cfg_value` at that edge, whatever `ctl_loop` is. In that output slot `dout_oe` is 0 and `dout` is undefined. With `ctl_load_n` high the cycle is idle and `cfg_value` holds.
- R9: Reads on consecutive cycles give consecutive output slots, each with its own pair and no idle gap.
- R10: After `rst_n` or `ctl_reset` is released, `dout_oe` stays 0 for LAT cycles.
- R11: `ctl_load_n` low with `ctl_rd_wrn` low writes the `din` pair to `addr`. A read returns the pair present at its sampling edge, so a write sampled one edge earlier is seen, and a later write is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_reset | input | 1 | Synchronous reset-state select, highest priority |
| ctl_cfg_wr | input | 1 | Configuration-write mode select |
| ctl_loop | input | 1 | Loopback mode select |
| ctl_load_n | input | 1 | Active-low command load |
| ctl_rd_wrn | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Array address, or configuration value |
| din | input | 2*DW | Write or loopback pair, first beat low |
| dout | output | 2*DW | Read or loopback pair, first beat low |
| dout_oe | output | 1 | Output slot carries driven data |
| cfg_value | output | AW | Configuration register |

## Verification
A command sampled at edge E sets `dout` and `dout_oe` just after edge E+LAT. A configuration write shows on `cfg_value` just after edge E itself. The bench drives inputs and samples outputs on falling edges. For each command it books the expected output slot LAT+1 falling edges ahead, in a table indexed by edge count. A synchronous reset overwrites every slot up to its own horizon, since it also clears the commands already in flight. At each falling edge the bench compares the booked slot and the configuration model.

// File: rtl/b2fe_pkg.sv
package b2fe_pkg;

  // Kind of a slot travelling down the latency chain
  typedef enum logic [2:0] {
    SLOT_IDLE = 3'd0,
    SLOT_WR   = 3'd1,
    SLOT_RD   = 3'd2,
    SLOT_CFG  = 3'd3,
    SLOT_LOOP = 3'd4
  } slot_kind_e;

endpackage

// File: rtl/b2fe_decode.sv
module b2fe_decode
  import b2fe_pkg::*;
(
  input  logic       ctl_reset,
  input  logic       ctl_cfg_wr,
  input  logic       ctl_loop,
  input  logic       ctl_load_n,
  input  logic       ctl_rd_wrn,
  output slot_kind_e kind,
  output logic       flush,
  output logic       mem_we,
  output logic       cfg_we
);

  // Fixed priority: reset, configuration write, loopback, memory (R3)
  always_comb begin
    kind = SLOT_IDLE;
    if (ctl_reset) begin
      kind = SLOT_IDLE;
    end else if (ctl_cfg_wr) begin
      kind = ctl_load_n ? SLOT_IDLE : SLOT_CFG;
    end else if (ctl_loop) begin
      kind = SLOT_LOOP;
    end else if (!ctl_load_n) begin
      kind = ctl_rd_wrn ? SLOT_RD : SLOT_WR;
    end
  end

  assign flush  = ctl_reset;
  assign mem_we = (kind == SLOT_WR);
  assign cfg_we = (kind == SLOT_CFG);

endmodule

// File: rtl/b2fe_store.sv
module b2fe_store #(
  parameter int AW = 3,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [PW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [PW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] mem_q [DEPTH];

  // Array holds no reset; content is defined once written
  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/b2fe_lat_pipe.sv
module b2fe_lat_pipe
  import b2fe_pkg::*;
#(
  parameter int LAT = 5,
  parameter int PW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  slot_kind_e    in_kind,
  input  logic [PW-1:0] in_data,
  output logic          out_oe,
  output logic [PW-1:0] out_data
);

  // LAT stages plus the output register: a slot sampled at edge E
  // reaches the pins just after edge E+LAT.
  for (genvar i = 0; i < LAT; i++) begin : g_st
    slot_kind_e    kind_q, kind_d, src_kind;
    logic [PW-1:0] data_q, data_d, src_data;

    if (i == 0) begin : g_head
      assign src_kind = in_kind;
      assign src_data = in_data;
    end else begin : g_body
      assign src_kind = g_st[i-1].kind_q;
      assign src_data = g_st[i-1].data_q;
    end

    always_comb begin
      kind_d = flush ? SLOT_IDLE : src_kind;
      data_d = flush ? '0 : src_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        kind_q <= SLOT_IDLE;
        data_q <= '0;
      end else begin
        kind_q <= kind_d;
        data_q <= data_d;
      end
    end
  end

  slot_kind_e    tail_kind;
  logic [PW-1:0] tail_data;
  logic          oe_d, oe_q;
  logic [PW-1:0] dout_d, dout_q;

  assign tail_kind = g_st[LAT-1].kind_q;
  assign tail_data = g_st[LAT-1].data_q;

  always_comb begin
    oe_d   = 1'b0;
    dout_d = '0;
    if (!flush) begin
      case (tail_kind)
        SLOT_RD, SLOT_LOOP: begin
          oe_d   = 1'b1;
          dout_d = tail_data;
        end
        SLOT_CFG: dout_d = 'x;
        default:  dout_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      oe_q   <= oe_d;
      dout_q <= dout_d;
    end
  end

  assign out_oe   = oe_q;
  assign out_data = dout_q;

endmodule

// File: rtl/b2fe_frontend.sv
module b2fe_frontend
  import b2fe_pkg::*;
#(
  parameter int AW  = 3,
  parameter int DW  = 8,
  parameter int LAT = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_reset,
  input  logic            ctl_cfg_wr,
  input  logic            ctl_loop,
  input  logic            ctl_load_n,
  input  logic            ctl_rd_wrn,
  input  logic [AW-1:0]   addr,
  input  logic [2*DW-1:0] din,
  output logic [2*DW-1:0] dout,
  output logic            dout_oe,
  output logic [AW-1:0]   cfg_value
);

  localparam int PW = 2 * DW;

  slot_kind_e    kind;
  logic          flush, mem_we, cfg_we;
  logic [PW-1:0] rdata, slot_data;
  logic [AW-1:0] cfg_d, cfg_q;

  b2fe_decode u_decode (
    .ctl_reset  (ctl_reset),
    .ctl_cfg_wr (ctl_cfg_wr),
    .ctl_loop   (ctl_loop),
    .ctl_load_n (ctl_load_n),
    .ctl_rd_wrn (ctl_rd_wrn),
    .kind       (kind),
    .flush      (flush),
    .mem_we     (mem_we),
    .cfg_we     (cfg_we)
  );

  b2fe_store #(.AW(AW), .PW(PW)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (addr),
    .wdata (din),
    .raddr (addr),
    .rdata (rdata)
  );

  // Read data is captured at the sampling edge and carried with the slot
  always_comb begin
    case (kind)
      SLOT_RD:   slot_data = rdata;
      SLOT_LOOP: slot_data = din;
      default:   slot_data = '0;
    endcase
  end

  b2fe_lat_pipe #(.LAT(LAT), .PW(PW)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .in_kind  (kind),
    .in_data  (slot_data),
    .out_oe   (dout_oe),
    .out_data (dout)
  );

  // Configuration register with written-out load enable
  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_value = cfg_q;

endmodule

// File: rtl/b2fe_frontend_chk.sv
module b2fe_frontend_chk #(
  parameter int AW  = 3,
  parameter int LAT = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_reset,
  input logic          ctl_cfg_wr,
  input logic          ctl_load_n,
  input logic [AW-1:0] addr,
  input logic          dout_oe,
  input logic [AW-1:0] cfg_value
);

  localparam int CW = $clog2(LAT + 2) + 1;

  logic [CW-1:0] since_q;

  // Edges since the last reset, saturating just past the latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
    end else if (ctl_reset) begin
      since_q <= '0;
    end else if (since_q <= CW'(LAT)) begin
      since_q <= since_q + 1'b1;
    end
  end

  logic cfg_load;
  assign cfg_load = !ctl_reset && ctl_cfg_wr && !ctl_load_n;

  p_flush_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> !dout_oe);

  p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (cfg_value == $past(addr)));

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(cfg_value));

  p_release_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q <= CW'(LAT)) |-> !dout_oe);

  always @(posedge clk) begin
    if (rst_n) begin
      p_oe_known_r7: assert (!$isunknown(dout_oe));
    end
  end

endmodule

bind b2fe_frontend b2fe_frontend_chk #(.AW(AW), .LAT(LAT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_reset  (ctl_reset),
  .ctl_cfg_wr (ctl_cfg_wr),
  .ctl_load_n (ctl_load_n),
  .addr       (addr),
  .dout_oe    (dout_oe),
  .cfg_value  (cfg_value)
);

// File: tb/b2fe_frontend_tb_top.sv
`timescale 1ns/1ps
module b2fe_frontend_tb_top;

  localparam int AW    = 3;
  localparam int DW    = 8;
  localparam int LAT   = 5;
  localparam int PW    = 2 * DW;
  localparam int DEPTH = 1 << AW;
  localparam int NSLOT = 2048;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctl_reset, ctl_cfg_wr, ctl_loop, ctl_load_n, ctl_rd_wrn;
  logic [AW-1:0] addr;
  logic [PW-1:0] din, dout;
  logic          dout_oe;
  logic [AW-1:0] cfg_value;

  always #2.5 clk = ~clk;

  b2fe_frontend #(.AW(AW), .DW(DW), .LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset), .ctl_cfg_wr(ctl_cfg_wr),
    .ctl_loop(ctl_loop), .ctl_load_n(ctl_load_n), .ctl_rd_wrn(ctl_rd_wrn),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .cfg_value(cfg_value)
  );

  logic          e_oe   [NSLOT];
  logic [PW-1:0] e_dout [NSLOT];
  logic          e_dchk [NSLOT];
  string         e_req  [NSLOT];

  logic [PW-1:0] m_mem [DEPTH];
  logic [AW-1:0] m_cfg, pend_val;
  logic          pend_cfg;
  int            cyc, total, bad;
  logic          done;

  function automatic logic [PW-1:0] pat(input int a, input int salt);
    return {8'(a * 29 + 5 + salt), 8'(a * 17 + 3 + salt * 7)};
  endfunction

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  task automatic set_slot(input int s, input logic oe, input logic [PW-1:0] d,
                          input logic dc, input string req);
    e_oe[s] = oe; e_dout[s] = d; e_dchk[s] = dc; e_req[s] = req;
  endtask

  task automatic step();
    @(posedge clk);
    cyc++;
    if (pend_cfg) begin
      m_cfg = pend_val;
      pend_cfg = 1'b0;
    end
    @(negedge clk);
    check(e_req[cyc], PW'(dout_oe), PW'(e_oe[cyc]));
    if (e_dchk[cyc]) check(e_req[cyc], dout, e_dout[cyc]);
    check("R8", PW'(cfg_value), PW'(m_cfg));
  endtask

  // Drive one command at a falling edge and book its output slot
  task automatic issue(input logic r, input logic cw, input logic lp, input logic ldn,
                       input logic rdw, input logic [AW-1:0] a, input logic [PW-1:0] d,
                       input string tag);
    int s;
    s = cyc + 1 + LAT;
    ctl_reset = r; ctl_cfg_wr = cw; ctl_loop = lp; ctl_load_n = ldn;
    ctl_rd_wrn = rdw; addr = a; din = d;
    if (r) begin
      for (int k = cyc + 1; k <= s; k++) set_slot(k, 1'b0, '0, 1'b1, "R1");
    end else if (cw) begin
      if (!ldn) begin
        set_slot(s, 1'b0, '0, 1'b0, "R8");
        pend_cfg = 1'b1;
        pend_val = a;
      end else begin
        set_slot(s, 1'b0, '0, 1'b1, "R8");
      end
    end else if (lp) begin
      set_slot(s, 1'b1, d, 1'b1, (tag != "") ? tag : "R4");
    end else if (ldn) begin
      set_slot(s, 1'b0, '0, 1'b1, (tag != "") ? tag : "R7");
    end else if (rdw) begin
      set_slot(s, 1'b1, m_mem[a], 1'b1, (tag != "") ? tag : "R6");
    end else begin
      m_mem[a] = d;
      set_slot(s, 1'b0, '0, 1'b1, (tag != "") ? tag : "R7");
    end
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(0, 0, 0, 1, 0, '0, '0, "R7");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    total = 0; bad = 0; cyc = 0; pend_cfg = 1'b0; m_cfg = '0; pend_val = '0;
    for (int k = 0; k < NSLOT; k++) set_slot(k, 1'b0, '0, 1'b1, "R10");
    rst_n = 1'b0;
    ctl_reset = 1'b0; ctl_cfg_wr = 1'b0; ctl_loop = 1'b0; ctl_load_n = 1'b1;
    ctl_rd_wrn = 1'b0; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    // R2: reset state of every output
    check("R2", PW'(dout_oe), '0);
    check("R2", dout, '0);
    check("R2", PW'(cfg_value), '0);
    rst_n = 1'b1;

    // R10: loopbacks right after release; earlier slots stay quiet
    for (int i = 0; i < 3; i++) issue(0, 0, 1, 1, 0, '0, pat(i, 9), "R10");
    idle(2);

    // R11: write sweep over every address
    for (int a = 0; a < DEPTH; a++) issue(0, 0, 0, 0, 0, AW'(a), pat(a, 0), "R11");
    // R9: back-to-back reads with no gaps
    for (int a = 0; a < DEPTH; a++) issue(0, 0, 0, 0, 1, AW'(a), '0, "R9");
    idle(2);

    // R5: idle cycles with every address and direction, then read back
    for (int a = 0; a < DEPTH; a++)
      for (int w = 0; w < 2; w++) issue(0, 0, 0, 1, w[0], AW'(a), pat(a, 3), "R5");
    for (int a = 0; a < DEPTH; a++) issue(0, 0, 0, 0, 1, AW'(a), '0, "R5");

    // R4: loopback with assorted load and direction pins, array untouched
    for (int i = 0; i < 8; i++)
      issue(0, 0, 1, i[0], i[1], AW'(i), pat(i, 11), "R4");
    for (int a = 0; a < DEPTH; a++) issue(0, 0, 0, 0, 1, AW'(a), '0, "R4");

    // R8 and R3: configuration writes, loopback pin alternating
    for (int a = 0; a < DEPTH; a++) issue(0, 1, a[0], 0, a[1], AW'(DEPTH - 1 - a), pat(a, 5), "R3");
    issue(0, 1, 0, 1, 0, 3'd5, '0, "R8");
    issue(0, 1, 1, 1, 1, 3'd6, '0, "R8");

    // R11: write then read next cycle; read then write then read
    issue(0, 0, 0, 0, 0, 3'd2, 16'hA55A, "R11");
    issue(0, 0, 0, 0, 1, 3'd2, '0, "R11");
    issue(0, 0, 0, 0, 1, 3'd4, '0, "R11");
    issue(0, 0, 0, 0, 0, 3'd4, 16'h3CC3, "R11");
    issue(0, 0, 0, 0, 1, 3'd4, '0, "R11");
    idle(2);

    // R1: reset mid-flight kills reads; write and config pins ignored
    for (int a = 0; a < 3; a++) issue(0, 0, 0, 0, 1, AW'(a), '0, "R6");
    issue(1, 1, 0, 0, 0, 3'd7, 16'hDEAD, "R1");
    issue(1, 0, 0, 0, 0, 3'd1, 16'hBEEF, "R1");
    issue(1, 0, 1, 0, 1, 3'd0, 16'h1234, "R1");
    // R10: reads issued at release appear only after the latency
    for (int a = 0; a < DEPTH; a++) issue(0, 0, 0, 0, 1, AW'(a), '0, "R6");
    idle(LAT + 2);
    finish_run();
  end

endmodule